// File: doc/BRIEF.md
# Strobed Byte-Stream Register Write Decoder

This block turns a narrow byte stream into register writes. A command is a run of bytes on an 8-bit bus in consecutive clock cycles. The strobe input is high only with the first byte. The first two bytes form a 16-bit address, low byte first. The remaining bytes form the write data, least significant byte first. When the final byte has been taken, the block compares the address with a base value. Only the bit positions selected by a mask take part in the compare. On a match it presents a short local register index, the assembled data word and a one-cycle write enable.

The stream has no valid or ready signal and cannot be held back. Once a strobe has been seen, the byte on the bus in each following cycle is taken as the next byte of the command. The write pulse has no ready either: the consumer must take each write in the cycle it is offered. A new strobe always wins. It drops whatever part of a command has been gathered so far and starts a fresh command with its own byte.

Parameters set the base, the mask, the number of bytes per command (3 to 6), the index width and the data width. The data width must be at least 8 × (bytes − 2). Data bits above the collected bytes read as zero.

Top module: `cmd_byte_deser`

## Requirements
- R1: A command is the byte marked by `cmd_first` followed by NBYTES−1 bytes in the next consecutive cycles. Byte 0 is the address low byte and byte 1 is the address high byte.
- R2: Data byte k (command byte k+2) lands in `wr_data[8k+7:8k]`. With the default of 6 bytes this fills all 32 bits.
- R3: A command is accepted only when `(addr & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`. On acceptance, `wr_idx` equals `addr[IDX_W-1:0]`. The defaults are base 0x0330, mask 0x07F8 and 3 index bits.
- R4: `wr_en` is high for exactly one cycle. That cycle starts at the clock edge that takes the last byte of an accepted command.
- R5: A command whose address does not match produces no `wr_en`.
- R6: A `cmd_first` in the middle of a command drops the partial command and starts a new one with that byte as address low.
- R7: Bytes without `cmd_first` while no command is open are ignored and never cause a write.
- R8: With fewer than 6 bytes per command, only NBYTES−2 data bytes are collected. With 3 bytes, `wr_data[31:8]` reads zero.
- R9: Asynchronous active-low reset clears the byte position, the gathered data, `wr_en`, `wr_idx` and `wr_data` at once.
- R10: `wr_idx` and `wr_data` keep the values of the last accepted write until the next accepted write.
- R11: A new command may start in the cycle right after the last byte of the previous one, and both are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_byte | input | 8 | Command byte bus |
| cmd_first | input | 1 | Marks the first byte of a command |
| wr_en | output | 1 | One-cycle write enable for an accepted command |
| wr_idx | output | IDX_W | Local register index from the low address bits |
| wr_data | output | DATA_W | Assembled write data |

## Verification
The write result of a command is due exactly one register stage after its last byte. The edge that takes that byte also sets `wr_en`, `wr_idx` and `wr_data`. The bench drives each byte on a falling edge. It samples the outputs on the falling edge right after the last byte and checks all three there. On the falling edge after that it checks that `wr_en` has dropped again. Misses, aborted commands and stray bytes are checked at the same falling edges, which confirms that no pulse appeared and that the held index and data did not move. For back-to-back commands, the sample is taken before the next strobe is driven on that same falling edge.

// File: rtl/cmd_deser_pkg.sv
package cmd_deser_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 16;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/deser_seq.sv
// Byte position tracker: which byte of a command is on the bus now.
module deser_seq
  import cmd_deser_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_i,
  output logic             take_o,
  output logic [CNT_W-1:0] lane_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  assign busy   = (cnt_q != '0);
  assign take_o = first_i | busy;
  assign lane_o = first_i ? '0 : cnt_q;
  assign last_o = !first_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (first_i) begin
      cnt_q <= ONE;
    end else if (busy) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + ONE;
    end
  end

  // R1: position never leaves the command length
  a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: a strobe always restarts at byte 1 next
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    first_i |=> (cnt_q == ONE));
  // R7: idle stays idle without a strobe
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !first_i) |=> (cnt_q == '0));
endmodule

// File: rtl/deser_pack.sv
// Gathers address and data bytes into their lanes.
module deser_pack
  import cmd_deser_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [CNT_W-1:0]  lane_i,
  input  byte_t             byte_i,
  output addr_t             addr_o,
  output logic [DATA_W-1:0] data_nx_o
);
  localparam int NDATA = NBYTES - ADDR_BYTES;
  localparam int FILL  = BYTE_W * NDATA;

  addr_t             addr_q, addr_nx;
  logic [DATA_W-1:0] data_q, data_nx;
  logic              start;

  assign start = take_i && (lane_i == '0);

  always_comb begin
    addr_nx = addr_q;
    if (start)
      addr_nx = {byte_t'(0), byte_i};
    else if (take_i && (lane_i == CNT_W'(1)))
      addr_nx[ADDR_W-1:BYTE_W] = byte_i;
  end

  for (genvar g = 0; g < NDATA; g++) begin : g_lane
    logic hit;
    assign hit = take_i && (lane_i == CNT_W'(g + ADDR_BYTES));
    assign data_nx[g*BYTE_W +: BYTE_W] =
      start ? byte_t'(0) : (hit ? byte_i : data_q[g*BYTE_W +: BYTE_W]);
  end

  if (DATA_W > FILL) begin : g_pad
    assign data_nx[DATA_W-1:FILL] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_nx;
      data_q <= data_nx;
    end
  end

  assign addr_o    = addr_q;
  assign data_nx_o = data_nx;

  // R1: second byte becomes the address high byte
  a_r1_addr_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && lane_i == CNT_W'(1)) |=> (addr_q[ADDR_W-1:BYTE_W] == $past(byte_i)));
  // R6: a fresh command starts from empty data
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (data_q == '0));
endmodule

// File: rtl/deser_match.sv
// Masked address compare and local index extraction.
module deser_match
  import cmd_deser_pkg::*;
#(
  parameter addr_t BASE_ADDR = 16'h0330,
  parameter addr_t ADDR_MASK = 16'h07F8,
  parameter int    IDX_W     = 3
) (
  input  addr_t             addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam addr_t REF = BASE_ADDR & ADDR_MASK;

  assign hit_o = ((addr_i & ADDR_MASK) == REF);
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/cmd_byte_deser.sv
module cmd_byte_deser
  import cmd_deser_pkg::*;
#(
  parameter addr_t BASE_ADDR = 16'h0330,
  parameter addr_t ADDR_MASK = 16'h07F8,
  parameter int    NBYTES    = 6,
  parameter int    IDX_W     = 3,
  parameter int    DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_byte,
  input  logic              cmd_first,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(NBYTES);

  logic              take_w, last_w, hit_w;
  logic [CNT_W-1:0]  lane_w;
  addr_t             addr_w;
  logic [DATA_W-1:0] data_nx_w;
  logic [IDX_W-1:0]  idx_w;

  deser_seq #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .first_i(cmd_first),
    .take_o(take_w), .lane_o(lane_w), .last_o(last_w)
  );

  deser_pack #(.NBYTES(NBYTES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take_i(take_w), .lane_i(lane_w),
    .byte_i(cmd_byte), .addr_o(addr_w), .data_nx_o(data_nx_w)
  );

  deser_match #(.BASE_ADDR(BASE_ADDR), .ADDR_MASK(ADDR_MASK), .IDX_W(IDX_W)) u_match (
    .addr_i(addr_w), .hit_o(hit_w), .idx_o(idx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= last_w && hit_w;
      if (last_w && hit_w) begin
        wr_idx  <= idx_w;
        wr_data <= data_nx_w;
      end
    end
  end

  // R4: the write pulse lasts a single cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R4: a pulse only follows the final byte of a command
  a_r4_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(last_w));
  // R10: outputs hold between accepted writes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_data) && $stable(wr_idx)));
endmodule

// File: tb/sim_cmd_byte_deser.sv
module sim_cmd_byte_deser;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  b0 = 8'h00, b1 = 8'h00;
  logic        f0 = 1'b0, f1 = 1'b0;
  logic        we0, we1;
  logic [2:0]  ix0, ix1;
  logic [31:0] d0, d1;

  int checks = 0;
  int fails  = 0;
  logic [2:0]  exp_idx  = '0;
  logic [31:0] exp_data = '0;

  cmd_byte_deser u0 (
    .clk(clk), .rst_n(rst_n), .cmd_byte(b0), .cmd_first(f0),
    .wr_en(we0), .wr_idx(ix0), .wr_data(d0)
  );

  cmd_byte_deser #(.NBYTES(3)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_byte(b1), .cmd_first(f1),
    .wr_en(we1), .wr_idx(ix1), .wr_data(d1)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dfun(input logic [15:0] a);
    return (32'(a) * 32'h9E3779B1) + 32'h01234567;
  endfunction

  function automatic bit hits(input logic [15:0] a);
    return (a & 16'h07F8) == 16'h0330;
  endfunction

  task automatic drv0(input bit f, input logic [7:0] v);
    @(negedge clk);
    f0 = f;
    b0 = v;
  endtask

  task automatic send0(input logic [15:0] a, input logic [31:0] d);
    drv0(1'b1, a[7:0]);
    drv0(1'b0, a[15:8]);
    for (int k = 0; k < 4; k++) drv0(1'b0, d[8*k +: 8]);
  endtask

  // sample one falling edge after the last byte, then confirm pulse end
  task automatic expect0(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    if (hits(a)) begin
      chk(we0 == 1'b1, "R4 write pulse", 64'(we0), 64'd1);
      chk(ix0 == a[2:0], "R3 index", 64'(ix0), 64'(a[2:0]));
      chk(d0 == d, "R2 data lanes", 64'(d0), 64'(d));
      exp_idx  = a[2:0];
      exp_data = d;
    end else begin
      chk(we0 == 1'b0, "R5 miss no pulse", 64'(we0), 64'd0);
      chk(d0 == exp_data && ix0 == exp_idx, "R10 hold on miss", 64'(d0), 64'(exp_data));
    end
    f0 = 1'b0;
    b0 = 8'h5A;
    @(negedge clk);
    chk(we0 == 1'b0, "R4 single cycle", 64'(we0), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(we0 == 1'b0 && ix0 == '0 && d0 == '0, "R9 reset state", 64'(d0), 64'd0);
    rst_n = 1'b1;

    // R3 R5 R2: sweep every low-12-bit address
    for (int i = 0; i < 4096; i++) begin
      send0(16'(i), dfun(16'(i)));
      expect0(16'(i), dfun(16'(i)));
    end
    // R3: bits outside the mask do not matter
    for (int k = 0; k < 32; k++) begin
      logic [15:0] a;
      a = 16'h0330 | 16'(k << 11) | 16'(k & 7);
      send0(a, ~dfun(a));
      expect0(a, ~dfun(a));
    end

    // R6: strobe mid-command aborts the partial one
    drv0(1'b1, 8'h31); drv0(1'b0, 8'h03); drv0(1'b0, 8'hEE);
    send0(16'h0335, 32'hCAFEF00D);
    expect0(16'h0335, 32'hCAFEF00D);
    drv0(1'b1, 8'h32); drv0(1'b0, 8'h03); drv0(1'b0, 8'h11); drv0(1'b0, 8'h22);
    send0(16'h1234, 32'h0BADBEEF);
    expect0(16'h1234, 32'h0BADBEEF);

    // R7: stray bytes while idle give nothing
    for (int k = 0; k < 8; k++) begin
      drv0(1'b0, (k % 2 == 0) ? 8'h30 : 8'h03);
      chk(we0 == 1'b0, "R7 idle bytes ignored", 64'(we0), 64'd0);
    end
    @(negedge clk);
    chk(we0 == 1'b0 && d0 == exp_data, "R7 outputs untouched", 64'(d0), 64'(exp_data));

    // R11: back-to-back commands
    send0(16'h0331, 32'h11112222);
    @(negedge clk);
    chk(we0 == 1'b1 && d0 == 32'h11112222, "R11 first of pair", 64'(d0), 64'h11112222);
    f0 = 1'b1; b0 = 8'h36;
    drv0(1'b0, 8'h03);
    drv0(1'b0, 8'h44); drv0(1'b0, 8'h33); drv0(1'b0, 8'h22); drv0(1'b0, 8'h11);
    @(negedge clk);
    chk(we0 == 1'b1 && ix0 == 3'd6 && d0 == 32'h11223344, "R11 second of pair", 64'(d0), 64'h11223344);
    exp_idx = 3'd6; exp_data = 32'h11223344;
    f0 = 1'b0;
    @(negedge clk);

    // R9: asynchronous reset mid-command, then leftover bytes
    drv0(1'b1, 8'h37); drv0(1'b0, 8'h03); drv0(1'b0, 8'h99);
    #2 rst_n = 1'b0;
    #1 chk(we0 == 1'b0 && ix0 == '0 && d0 == '0, "R9 async clear", 64'(d0), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_idx = '0; exp_data = '0;
    for (int k = 0; k < 4; k++) drv0(1'b0, 8'h77);
    for (int k = 0; k < 3; k++) begin
      drv0(1'b0, 8'h00);
      chk(we0 == 1'b0 && d0 == '0, "R9 counter cleared", 64'(d0), 64'd0);
    end
    send0(16'h0337, 32'h89ABCDEF);
    expect0(16'h0337, 32'h89ABCDEF);

    // R8: three-byte commands, one data byte, upper bits zero
    for (int v = 0; v < 256; v++) begin
      logic [15:0] a;
      a = 16'h0330 | 16'(v & 7);
      @(negedge clk); f1 = 1'b1; b1 = a[7:0];
      @(negedge clk); f1 = 1'b0; b1 = a[15:8];
      @(negedge clk); b1 = 8'(v);
      @(negedge clk);
      chk(we1 == 1'b1 && ix1 == a[2:0] && d1 == 32'(v), "R8 short command", 64'(d1), 64'(v));
      b1 = 8'hFF;
      @(negedge clk);
      chk(we1 == 1'b0 && d1 == 32'(v), "R8 pulse and hold", 64'(d1), 64'(v));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule